// File: doc/BRIEF.md
# Sparse Crosspoint Concentrator

This block gathers the active lanes among a wide set of input channels and packs them onto a narrower set of output channels. The order of the outputs carries no meaning, so the block gets by with fewer crosspoints than a full crossbar. Each output channel is wired to a contiguous window of only N−K+1 inputs, which gives K(N−K+1) crosspoints in total. The assignment logic picks, for every active input, an output inside its own window, and no two inputs ever pick the same output.

An input channel asserts its valid bit and presents a data word. After one clock, each output carries a valid bit, the data word and the index of the input it came from. When more inputs are active than there are outputs, the lowest-indexed K of them are carried and an overflow flag is raised for that cycle. The block is combinational up to a single output register stage and uses a synchronous active-high reset.

Top module: `spx_concentrator`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `out_valid`, `out_data`, `out_src` and `overflow` all zero.
- R2: Outputs change only at a clock edge, and they reflect the inputs sampled at the previous edge. Latency is exactly one cycle.
- R3: `overflow` is 1 exactly when more than K bits of the sampled `in_valid` were set.
- R4: When at most K inputs are active, each active input appears on exactly one output, with its own data word. That output's `out_src` field (SW bits, lane j at bits [j*SW +: SW]) holds the input's index.
- R5: Output j is fed only by inputs with index i where j ≤ i ≤ j+(N−K).
- R6: Let r be the number of active inputs with a lower index than input i. An active, routed input i goes to output max(r, i−(N−K)).
- R7: An output with no assigned input drives valid 0, data 0 and source index 0.
- R8: When more than K inputs are active, only those with r < K are routed, so exactly K outputs are valid.
- R9: The data of an inactive input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | One valid bit per input channel |
| in_data | input | N*W | Input data, lane i at bits [i*W +: W] |
| out_valid | output | K | One valid bit per output channel |
| out_data | output | K*W | Output data, lane j at bits [j*W +: W] |
| out_src | output | K*SW | Source input index per output, SW = log2(N) |
| overflow | output | 1 | More than K inputs were active |

## Verification
The bench uses the default parameters: N=16, K=6 and an 8-bit data width. With these values all 65,536 patterns of `in_valid` fit in a short run, so the bench sweeps every active set once. That sweep covers every size from empty to full, every overflow case, and every position at which an input can be pushed to the edge of its window. The data of inactive lanes is randomized on each pattern, which exposes any leakage from those lanes into the outputs.

// File: rtl/spx_pkg.sv
package spx_pkg;
  function automatic int spx_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spx_rank.sv
module spx_rank #(
  parameter int N  = 16,
  parameter int K  = 6,
  parameter int TW = 3
) (
  input  logic [N-1:0]    valid_i,
  output logic [N-1:0]    route_o,
  output logic [N*TW-1:0] tgt_o,
  output logic            overflow_o
);
  import spx_pkg::*;
  localparam int SLACK = N - K;

  always_comb begin
    int cnt;
    cnt = 0;
    route_o = '0;
    tgt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && cnt < K) begin
        route_o[i] = 1'b1;
        tgt_o[i*TW +: TW] = TW'(spx_max(cnt, i - SLACK));
      end
      if (valid_i[i]) cnt = cnt + 1;
    end
    overflow_o = (cnt > K);
  end
endmodule

// File: rtl/spx_column.sv
module spx_column #(
  parameter int N  = 16,
  parameter int K  = 6,
  parameter int W  = 8,
  parameter int SW = 4,
  parameter int TW = 3,
  parameter int J  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    route_i,
  input  logic [N*TW-1:0] tgt_i,
  input  logic [N*W-1:0]  data_i,
  output logic            valid_o,
  output logic [W-1:0]    data_o,
  output logic [SW-1:0]   src_o
);
  localparam int C = N - K + 1;
  logic [C-1:0] hit;

  for (genvar c = 0; c < C; c++) begin : g_xp
    assign hit[c] = route_i[J+c] && (tgt_i[(J+c)*TW +: TW] == TW'(J));
  end

  always_comb begin
    valid_o = |hit;
    data_o = '0;
    src_o = '0;
    for (int c = 0; c < C; c++) begin
      if (hit[c]) begin
        data_o = data_o | data_i[(J+c)*W +: W];
        src_o = src_o | SW'(J + c);
      end
    end
  end

  // R4: no two inputs claim the same output
  assert_single_claim_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/spx_outreg.sv
module spx_outreg #(
  parameter int N  = 16,
  parameter int K  = 6,
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [K-1:0]    valid_i,
  input  logic [K*W-1:0]  data_i,
  input  logic [K*SW-1:0] src_i,
  input  logic            ovf_i,
  output logic [K-1:0]    valid_o,
  output logic [K*W-1:0]  data_o,
  output logic [K*SW-1:0] src_o,
  output logic            ovf_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= '0;
      data_o <= '0;
      src_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      data_o <= data_i;
      src_o <= src_i;
      ovf_o <= ovf_i;
    end
  end

  for (genvar j = 0; j < K; j++) begin : g_chk
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
      !valid_o[j] |-> (data_o[j*W +: W] == '0 && src_o[j*SW +: SW] == '0));
    assert_window_R5: assert property (@(posedge clk) disable iff (rst)
      valid_o[j] |-> (int'(src_o[j*SW +: SW]) >= j &&
                      int'(src_o[j*SW +: SW]) <= j + N - K));
  end
endmodule

// File: rtl/spx_concentrator.sv
module spx_concentrator #(
  parameter int N  = 16,
  parameter int K  = 6,
  parameter int W  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    in_valid,
  input  logic [N*W-1:0]  in_data,
  output logic [K-1:0]    out_valid,
  output logic [K*W-1:0]  out_data,
  output logic [K*SW-1:0] out_src,
  output logic            overflow
);
  localparam int TW = (K > 1) ? $clog2(K) : 1;

  logic [N-1:0]    route;
  logic [N*TW-1:0] tgt;
  logic            ovf_c;
  logic [K-1:0]    col_valid;
  logic [K*W-1:0]  col_data;
  logic [K*SW-1:0] col_src;

  spx_rank #(.N(N), .K(K), .TW(TW)) u_rank (
    .valid_i(in_valid), .route_o(route), .tgt_o(tgt), .overflow_o(ovf_c)
  );

  for (genvar j = 0; j < K; j++) begin : g_col
    spx_column #(.N(N), .K(K), .W(W), .SW(SW), .TW(TW), .J(j)) u_col (
      .clk(clk), .rst(rst), .route_i(route), .tgt_i(tgt), .data_i(in_data),
      .valid_o(col_valid[j]), .data_o(col_data[j*W +: W]),
      .src_o(col_src[j*SW +: SW])
    );
  end

  spx_outreg #(.N(N), .K(K), .W(W), .SW(SW)) u_out (
    .clk(clk), .rst(rst), .valid_i(col_valid), .data_i(col_data),
    .src_i(col_src), .ovf_i(ovf_c), .valid_o(out_valid), .data_o(out_data),
    .src_o(out_src), .ovf_o(overflow)
  );

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (overflow == ($countones($past(in_valid)) > K)));
  assert_out_count_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(out_valid) ==
      (($countones($past(in_valid)) > K) ? K : $countones($past(in_valid)))));
endmodule

// File: tb/spx_concentrator_bench.sv
module spx_concentrator_bench;
  localparam int N = 16, K = 6, W = 8, SW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic [K-1:0] out_valid;
  logic [K*W-1:0] out_data;
  logic [K*SW-1:0] out_src;
  logic overflow;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [K-1:0] ev;
  logic [K*W-1:0] ed;
  logic [K*SW-1:0] es;
  logic eo;

  spx_concentrator #(.N(N), .K(K), .W(W), .SW(SW)) u_spx_concentrator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
    .overflow(overflow)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] lane_word(int p, int i);
    return W'(i * 29 + p * 7 + 3);
  endfunction

  task automatic drive(input int p);
    in_valid = N'(p);
    for (int i = 0; i < N; i++)
      in_data[i*W +: W] = in_valid[i] ? lane_word(p, i) : W'($urandom);
  endtask

  // Expected outputs from R3, R6, R7, R8
  task automatic expect_for(input int p);
    int r;
    int j;
    ev = '0; ed = '0; es = '0; r = 0;
    for (int i = 0; i < N; i++) begin
      if (p[i]) begin
        if (r < K) begin
          j = (r > i - (N - K)) ? r : i - (N - K);
          ev[j] = 1'b1;
          ed[j*W +: W] = lane_word(p, i);
          es[j*SW +: SW] = SW'(i);
        end
        r++;
      end
    end
    eo = (r > K);
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input int p);
    chk(overflow == eo, "R3 overflow", 128'(overflow), 128'(eo));
    chk(out_valid == ev, "R4/R8 valid set", 128'(out_valid), 128'(ev));
    chk(out_src == es, "R5/R6 source indices", 128'(out_src), 128'(es));
    chk(out_data == ed, "R4/R7/R9 data lanes", 128'(out_data), 128'(ed));
    if (p == 16'h8000)
      chk(out_valid == 6'b100000, "R5 lone top input at last output",
          128'(out_valid), 128'h20);
  endtask

  initial begin
    // R1: reset with every input active
    drive(16'hFFFF);
    repeat (3) @(negedge clk);
    chk(out_valid == '0 && overflow == 1'b0, "R1 reset valid/overflow",
        128'({overflow, out_valid}), 128'(0));
    chk(out_data == '0 && out_src == '0, "R1 reset data/src",
        128'({out_data, out_src}), 128'(0));
    rst = 1'b0;
    drive(0);
    @(negedge clk);
    // R2: new inputs do not appear before the next edge
    drive(16'h0421);
    #5;
    chk(out_valid == '0, "R2 no change before edge", 128'(out_valid), 128'(0));
    @(negedge clk);
    expect_for(16'h0421);
    chk(out_valid == ev, "R2 one-cycle latency", 128'(out_valid), 128'(ev));
    // R9: change inactive data only, outputs unchanged
    for (int i = 0; i < N; i++)
      if (!in_valid[i]) in_data[i*W +: W] = ~in_data[i*W +: W];
    @(negedge clk);
    chk(out_data == ed, "R9 inactive data ignored", 128'(out_data), 128'(ed));
    // Exhaustive sweep of all valid patterns
    drive(0);
    @(negedge clk);
    for (int p = 0; p < (1 << N); p++) begin
      drive(p);
      @(negedge clk);
      expect_for(p);
      check_all(p);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule